// File: doc/BRIEF.md
# Sixteen-CPU Interrupt Distributor

This block collects interrupt lines from the rest of the chip and forwards each one to a chosen set of CPU interfaces, for up to sixteen CPUs. Every interrupt has its own enable bit and a CPU target field. A single global enable can stop all forwarding at once. The result is one flat pending vector per CPU, and a CPU interface stage turns that vector into an interrupt request.

IDs 0 to 31 are private to each CPU. IDs 0 to 15 are software-generated: any CPU raises them by writing a CPU map to one register. IDs 16 to 31 are per-CPU peripheral inputs. For private IDs, the enable and pending state is banked, so each access works on the bank of the CPU named on the bus. IDs 32 and up are shared lines. Each shared line is level-high or rising-edge triggered. The register bus takes word addresses, 32-bit data and the number of the accessing CPU. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_distributor`

## Requirements
- R1: After reset every `cpu_irq` bit is 0. The control word (word 0) reads 0. All enables, targets and pending latches are 0, and every configurable line is level triggered.
- R2: The enable-set words (word 64 + ID/32) and enable-clear words (word 96 + ID/32) use bit ID mod 32. Writing 1 sets or clears that enable. Writing 0 leaves it unchanged. Both word arrays read back the current enables.
- R3: The target field of shared ID n is in word 512 + n/2. Even IDs use bits 15:0 and odd IDs use bits 31:16, and bit c of a field names CPU c. Only the low NCPU bits are stored and read back, and the other bits read 0.
- R4: Reading any of words 512 to 527 returns the one-hot bit of the accessing CPU in both halves.
- R5: Writing word 960 with an ID in bits 3:0 and a CPU map in bits 23:8 sets that software interrupt pending for every existing CPU in the map. Map bits for CPUs that do not exist have no effect.
- R6: For IDs 0 to 31, the enables and pending latches are banked per CPU. One CPU's writes never change what another CPU reads or receives.
- R7: IDs 0 to 15 always read as edge triggered (1) in trigger word 192. Writes to bits 15:0 of that word are ignored.
- R8: A trigger bit of 1 (trigger words 192 + ID/32) selects rising edge. A rising edge latches pending, and the latch holds until a 1 is written to the ID's bit in the pending-clear word (word 160 + ID/32). A held-high input does not latch again.
- R9: A trigger bit of 0 selects level. The line is then pending exactly while its input is high.
- R10: When control bit 0 is 0, every `cpu_irq` bit is 0.
- R11: The type word (word 1) bits 4:0 hold NIRQ/32 − 1. IDs 510 and above are never forwarded.
- R12: A shared interrupt whose target field is all zeros reaches no CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_cpu | input | 4 | Number of the CPU making the access |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_in | input | NIRQ-32 | Shared lines; bit k is ID 32+k |
| ppi_in | input | NCPU*16 | Private lines; bit c*16+j is ID 16+j of CPU c |
| cpu_irq | output | NCPU*NIRQ | Forwarded pending; bit c*NIRQ+n is ID n for CPU c |

## Verification
A wrong enable bit, target bit or pending latch shows up on `cpu_irq` in the first cycle after the write or the input change that exposes it. The register read path shows the same error one cycle after the read strobe. The bench sweeps every shared ID with its own target pattern and every software ID with its own CPU map. A bit routed to the wrong CPU therefore changes an exact per-CPU bit and also the total count of set bits. Banking faults show up when a second CPU reads or receives state that it never wrote.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  parameter int AW   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [3:0]             bus_cpu,
  input  logic [AW-1:0]          bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NIRQ-33:0]       spi_in,
  input  logic [NCPU*16-1:0]     ppi_in,
  output logic [NCPU*NIRQ-1:0]   cpu_irq
);
  localparam int NW   = NIRQ / 32;
  localparam int NLIM = (NIRQ > 510) ? 510 : NIRQ;
  localparam int NS   = NLIM - 32;
  localparam int CTL = 0, TYP = 1, ENS = 64, ENC = 96, PCL = 160, TRG = 192, TGT = 512, SGI = 960;

  logic            ctl_en;
  logic [NS-1:0]   en_s, trg_s, lat_s, spi_q, ps;
  logic [NCPU-1:0] tgt_s [NS];
  logic [15:0]     trg_p;
  logic [31:0]     en_p [NCPU];
  logic [31:0]     lat_p [NCPU];
  logic [31:0]     lat_n [NCPU];
  logic [31:0]     pp [NCPU];
  logic [15:0]     ppi_q [NCPU];
  logic [31:0]     rv;

  wire wr_sgi = bus_wr && bus_addr == AW'(SGI);

  assign ps = (trg_s & lat_s) | (~trg_s & spi_in[NS-1:0]);

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      lat_n[c] = lat_p[c];
      if (bus_wr && bus_cpu == 4'(c) && bus_addr == AW'(PCL)) lat_n[c] = lat_n[c] & ~bus_wdata;
      if (wr_sgi && bus_wdata[8+c]) lat_n[c][bus_wdata[3:0]] = 1'b1;
      for (int j = 0; j < 16; j++)
        if (trg_p[j] && ppi_in[c*16+j] && !ppi_q[c][j]) lat_n[c][16+j] = 1'b1;
      pp[c] = lat_p[c];
      for (int j = 0; j < 16; j++)
        if (!trg_p[j]) pp[c][16+j] = ppi_in[c*16+j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      en_s   <= '0;
      trg_s  <= '0;
      lat_s  <= '0;
      spi_q  <= '0;
      trg_p  <= '0;
      for (int k = 0; k < NS; k++) tgt_s[k] <= '0;
      for (int c = 0; c < NCPU; c++) begin
        en_p[c]  <= '0;
        lat_p[c] <= '0;
        ppi_q[c] <= '0;
      end
    end else begin
      spi_q <= spi_in[NS-1:0];
      if (bus_wr && bus_addr == AW'(CTL)) ctl_en <= bus_wdata[0];
      if (bus_wr && bus_addr == AW'(TRG)) trg_p <= bus_wdata[31:16];
      for (int k = 0; k < NS; k++) begin
        if (bus_wr && bus_addr == AW'(ENS + (k+32)/32) && bus_wdata[(k+32)%32]) en_s[k] <= 1'b1;
        if (bus_wr && bus_addr == AW'(ENC + (k+32)/32) && bus_wdata[(k+32)%32]) en_s[k] <= 1'b0;
        if (bus_wr && bus_addr == AW'(TRG + (k+32)/32)) trg_s[k] <= bus_wdata[(k+32)%32];
        if (bus_wr && bus_addr == AW'(TGT + (k+32)/2)) tgt_s[k] <= bus_wdata[((k+32)%2)*16 +: NCPU];
        if (bus_wr && bus_addr == AW'(PCL + (k+32)/32) && bus_wdata[(k+32)%32]) lat_s[k] <= 1'b0;
        if (trg_s[k] && spi_in[k] && !spi_q[k]) lat_s[k] <= 1'b1;
      end
      for (int c = 0; c < NCPU; c++) begin
        ppi_q[c] <= ppi_in[c*16 +: 16];
        lat_p[c] <= lat_n[c];
        if (bus_wr && bus_cpu == 4'(c)) begin
          if (bus_addr == AW'(ENS)) en_p[c] <= en_p[c] | bus_wdata;
          else if (bus_addr == AW'(ENC)) en_p[c] <= en_p[c] & ~bus_wdata;
        end
      end
    end
  end

  genvar gc, gi;
  generate
    for (gc = 0; gc < NCPU; gc++) begin : g_cpu
      for (gi = 0; gi < NIRQ; gi++) begin : g_id
        if (gi < 32) begin : g_priv
          assign cpu_irq[gc*NIRQ+gi] = ctl_en & en_p[gc][gi] & pp[gc][gi];
        end else if (gi < NLIM) begin : g_shr
          assign cpu_irq[gc*NIRQ+gi] = ctl_en & en_s[gi-32] & ps[gi-32] & tgt_s[gi-32][gc];
        end else begin : g_none
          assign cpu_irq[gc*NIRQ+gi] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    rv = '0;
    if (bus_addr == AW'(CTL)) rv[0] = ctl_en;
    if (bus_addr == AW'(TYP)) rv[4:0] = 5'(NW - 1);
    if (bus_addr == AW'(TRG)) rv = {trg_p, 16'hFFFF};
    if (bus_addr >= AW'(TGT) && bus_addr < AW'(TGT + 16)) rv = {2{16'd1 << bus_cpu}};
    for (int c = 0; c < NCPU; c++)
      if (bus_cpu == 4'(c)) begin
        if (bus_addr == AW'(ENS) || bus_addr == AW'(ENC)) rv = en_p[c];
        if (bus_addr == AW'(PCL)) rv = pp[c];
      end
    for (int k = 0; k < NS; k++) begin
      if (bus_addr == AW'(ENS + (k+32)/32) || bus_addr == AW'(ENC + (k+32)/32)) rv[(k+32)%32] = en_s[k];
      if (bus_addr == AW'(PCL + (k+32)/32)) rv[(k+32)%32] = ps[k];
      if (bus_addr == AW'(TRG + (k+32)/32)) rv[(k+32)%32] = trg_s[k];
      if (bus_addr == AW'(TGT + (k+32)/2)) rv[((k+32)%2)*16 +: NCPU] = tgt_s[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rv;
  end

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> cpu_irq == '0);
  // R5
  sgi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sgi && bus_wdata[8] |=> lat_p[0][$past(bus_wdata[3:0])]);
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(ENS + 1) && bus_wdata[0] |=> en_s[0]);
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(ENC + 1) && bus_wdata[0] |=> !en_s[0]);
  // R2
  en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(ENC + 1) && !bus_wdata[0] |=> en_s[0] == $past(en_s[0]));
  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trg_s[0] && lat_s[0] && !(bus_wr && bus_addr == AW'(PCL + 1) && bus_wdata[0]) |=> lat_s[0]);
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  localparam int ENS = 64, ENC = 96, PCL = 160, TRG = 192, TGT = 512, SGI = 960;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_cpu = 0;
  logic [9:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, rd0, rd1;
  logic [31:0] spi = 0;
  logic [63:0] ppi = 0;
  logic [255:0] irq;
  logic [479:0] spi2 = 0;
  logic [31:0] ppi2 = 0;
  logic [1023:0] irq2;
  int nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  irq_distributor #(.NCPU(4), .NIRQ(64)) u_dut (.clk, .rst_n, .bus_wr, .bus_rd, .bus_cpu,
    .bus_addr, .bus_wdata, .bus_rdata(rd0), .spi_in(spi), .ppi_in(ppi), .cpu_irq(irq));
  irq_distributor #(.NCPU(2), .NIRQ(512)) u_cap (.clk, .rst_n, .bus_wr, .bus_rd, .bus_cpu,
    .bus_addr, .bus_wdata, .bus_rdata(rd1), .spi_in(spi2), .ppi_in(ppi2), .cpu_irq(irq2));

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int cpu, int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_cpu = 4'(cpu); bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int cpu, int a);
    @(negedge clk);
    bus_rd = 1; bus_cpu = 4'(cpu); bus_addr = 10'(a);
    @(negedge clk);
    bus_rd = 0;
  endtask

  function automatic logic [3:0] tf(int id);
    return 4'((id * 7 + 3) & 15);
  endfunction

  initial begin
    #(20ns * 200000);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq idle", 64'(irq == '0), 1);
    rd(0, 0); chk("R1 ctrl", 64'(rd0), 0);
    rd(0, 1); chk("R11 type", 64'(rd0), 1); chk("R11 type cap", 64'(rd1), 15);
    wr(0, 0, 1);

    // R3 target packing with junk upper bits
    for (int id = 32; id < 64; id += 2)
      wr(0, TGT + id/2, {16'hA5A0 | 16'(tf(id+1)), 16'h5A50 | 16'(tf(id))});
    for (int id = 32; id < 64; id += 2) begin
      rd(0, TGT + id/2);
      chk("R3 target word", 64'(rd0), 64'({16'(tf(id+1)), 16'(tf(id))}));
    end
    // R4
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 16; w += 5) begin
        rd(c, TGT + w);
        chk("R4 own cpu bit", 64'(rd0), 64'({2{16'd1 << c}}));
      end
    // R2
    wr(0, ENS + 1, 32'h5555_5555); rd(0, ENS + 1); chk("R2 set", 64'(rd0), 64'h5555_5555);
    wr(0, ENC + 1, 32'h0000_0005); rd(0, ENC + 1); chk("R2 clear", 64'(rd0), 64'h5555_5550);
    wr(0, ENS + 1, 32'hFFFF_FFFF); rd(0, ENS + 1); chk("R2 all", 64'(rd0), 64'hFFFF_FFFF);
    // R9 R12 routing sweep
    for (int id = 32; id < 64; id++) begin
      @(negedge clk); spi = 32'd1 << (id - 32); #1;
      for (int c = 0; c < 4; c++) chk("R9 R12 route", 64'(irq[c*64+id]), 64'(tf(id)[c]));
      chk("R3 R12 count", 64'($countones(irq)), 64'($countones(tf(id))));
    end
    @(negedge clk); spi = 0; #1;
    chk("R9 level drop", 64'(irq == '0), 1);
    // R10
    @(negedge clk); spi = '1;
    wr(0, 0, 0); chk("R10 disabled", 64'(irq == '0), 1);
    wr(0, 0, 1); chk("R10 enabled", 64'(irq[40]), 64'(tf(40)[0]));
    @(negedge clk); spi = 0;
    // R8 edge on id 40 (target cpus 0,1,3)
    wr(0, TRG + 1, 32'h0000_0100);
    @(negedge clk); spi[8] = 1;
    @(negedge clk); spi[8] = 0;
    @(negedge clk);
    chk("R8 latched", 64'({irq[3*64+40], irq[2*64+40], irq[64+40], irq[40]}), 64'hB);
    @(negedge clk); spi[8] = 1;
    @(negedge clk);
    wr(0, PCL + 1, 32'h0000_0100);
    @(negedge clk);
    chk("R8 cleared while held", 64'(irq[40]), 0);
    @(negedge clk); spi[8] = 0;
    // R6 banking
    wr(0, ENS, 32'h0000_FFFF);
    rd(1, ENS); chk("R6 bank isolated", 64'(rd0), 0);
    rd(0, ENS); chk("R6 bank own", 64'(rd0), 64'h0000_FFFF);
    for (int c = 1; c < 4; c++) wr(c, ENS, 32'h0000_FFFF);
    // R5 SGI sweep
    for (int id = 0; id < 16; id++) begin
      logic [3:0] m;
      m = 4'((id * 5 + 1) & 15);
      wr(id % 4, SGI, {8'h00, 16'hFF00 | 16'(m), 4'h0, 4'(id)});
      for (int c = 0; c < 4; c++) chk("R5 sgi", 64'(irq[c*64+id]), 64'(m[c]));
      chk("R5 sgi count", 64'($countones(irq)), 64'($countones(m)));
      for (int c = 0; c < 4; c++) wr(c, PCL, 32'd1 << id);
      chk("R5 sgi cleared", 64'(irq == '0), 1);
    end
    // R6 private level line
    wr(2, ENS, 32'h0001_0000);
    @(negedge clk); ppi[32] = 1; #1;
    chk("R6 ppi own cpu", 64'(irq[2*64+16]), 1);
    chk("R6 ppi others", 64'($countones(irq)), 1);
    @(negedge clk); ppi[32] = 0;
    // R7
    wr(0, TRG, 32'h0000_0000);
    rd(0, TRG); chk("R7 sgi fixed edge", 64'(rd0), 64'h0000_FFFF);
    // R11 cap
    wr(0, TGT + 254, 32'h0001_0001);
    wr(0, TGT + 255, 32'h0001_0001);
    wr(0, ENS + 15, 32'hFFFF_FFFF);
    @(negedge clk); spi2[477] = 1; spi2[478] = 1; #1;
    chk("R11 id 509 forwarded", 64'(irq2[509]), 1);
    chk("R11 id 510 blocked", 64'(irq2[510]), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule